// File: doc/BRIEF.md
# Interleaved Multi-Channel First-Order Recursive Filter

This block runs N independent first-order recursive filters on one shared multiply-add unit. Each channel obeys z(k) = x(k) + c·z(k−1), the transfer function 1/(1 − c·z⁻¹). The samples of all channels share one input port in a fixed rotation: channel 0, 1, …, N−1, then channel 0 again, one sample every clock. The shared datapath therefore runs N times faster than any single channel. A marker input flags the channel-0 slot, and the block returns it aligned with the output stream.

The feedback loop contains exactly N registers. The multiplier holds MUL_STG of them, the adder holds ADD_STG, and a balancing delay holds the remaining N − MUL_STG − ADD_STG. This makes each channel's previous result arrive back at the adder in the same cycle as that channel's next input. The product is rounded and saturated before the add, and the sum is saturated. A parameter set with MUL_STG < 1, ADD_STG < 1 or MUL_STG + ADD_STG > N stops elaboration with an error. The parallel-to-serial and serial-to-parallel conversion stay outside the block.

Top module: `iirx_interleave`

## Requirements
- R1: For every input sample, out_data is sat(x + q), where q is the rounded and saturated product of coef and the same channel's previous result. The value of coef is signed with CF = 14 fractional bits, so 16384 stands for +1.0.
- R2: The channel of a sample is its cycle position modulo N_CH, counted from any fixed cycle. Feedback for a channel comes only from the output of the sample N_CH cycles earlier, so the channels never mix.
- R3: Rounding adds 2^(CF−1) to the full product and shifts it right arithmetically by CF bits, so exact halves round towards +infinity: 1.5 → 2 and −499.5 → −499.
- R4: The rounded product is clamped to the signed DW-bit range [−32768, 32767] before the add.
- R5: The sum is clamped to the signed DW-bit range [−32768, 32767].
- R6: The result for an input sampled at clock edge e appears on out_data after edge e + ADD_STG − 1, a latency of ADD_STG cycles (1 by default).
- R7: While rst_n is low, every loop register is cleared at once and out_data and out_first read 0. Every channel restarts from z(−1) = 0, and out_data stays 0 for the first ADD_STG edges after release.
- R8: While coef has been 0 for longer than the loop pipeline, out_data equals in_data delayed by ADD_STG cycles.
- R9: out_first equals in_first delayed by ADD_STG cycles, so it marks the result of the channel-0 sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one interleaved sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_data | input | DW | Interleaved signed input sample |
| in_first | input | 1 | High on the channel-0 input slot |
| coef | input | CW | Signed feedback coefficient, CF fractional bits |
| out_data | output | DW | Interleaved signed filter result |
| out_first | output | 1 | High on the channel-0 result slot |

## Verification
The bound checker covers, on every cycle, the properties that follow from port histories alone:
- the quiet output after reset;
- the marker delayed by the adder depth;
- pass-through while the coefficient has been held at zero;
- outputs that are never unknown.

The arithmetic cannot be checked that way. Rounding of exact halves, the two clamps and the per-channel separation of the feedback need a reference recursion, so only the bench scenarios show them. Those scenarios are impulses that decay under a positive coefficient, a negative coefficient, inputs driven near full scale, and a reset asserted in the middle of a stream.

// File: rtl/iirx_pkg.sv
`timescale 1ns/1ps
package iirx_pkg;
  localparam int ACC_W = 64;
  typedef logic signed [ACC_W-1:0] acc_t;

  // Clamp a wide signed value into the signed range of w bits.
  function automatic acc_t clamp_w(input acc_t v, input int w);
    acc_t top;
    acc_t bot;
    top = (acc_t'(1) <<< (w - 1)) - acc_t'(1);
    bot = -(acc_t'(1) <<< (w - 1));
    if (v > top) return top;
    if (v < bot) return bot;
    return v;
  endfunction
endpackage

// File: rtl/iirx_delay.sv
`timescale 1ns/1ps
module iirx_delay #(
  parameter int W = 8,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (D == 0) begin : g_wire
      assign q_o = d_i;
    end else begin : g_pipe
      logic [W-1:0] stg_q [D];
      logic [W-1:0] stg_d [D];

      always_comb begin
        stg_d[0] = d_i;
        for (int k = 1; k < D; k++) stg_d[k] = stg_q[k-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < D; k++) stg_q[k] <= '0;
        end else begin
          stg_q <= stg_d;
        end
      end

      assign q_o = stg_q[D-1];
    end
  endgenerate
endmodule

// File: rtl/iirx_mul.sv
`timescale 1ns/1ps
module iirx_mul
  import iirx_pkg::*;
#(
  parameter int DW  = 16,
  parameter int CW  = 16,
  parameter int CF  = 14,
  parameter int STG = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] z_i,
  input  logic signed [CW-1:0] c_i,
  output logic signed [DW-1:0] p_o
);
  localparam int PW = DW + CW;

  logic signed [PW-1:0] raw;
  logic signed [PW-1:0] raw_q;
  acc_t                 rnd;

  // Full-precision product, registered STG times inside the loop.
  assign raw = PW'(z_i) * PW'(c_i);

  iirx_delay #(.W(PW), .D(STG)) u_pipe (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw),
    .q_o  (raw_q)
  );

  // Round half up, drop the fraction, clamp to the data width.
  always_comb begin
    rnd = (acc_t'(raw_q) + (acc_t'(1) <<< (CF - 1))) >>> CF;
    p_o = DW'(clamp_w(rnd, DW));
  end
endmodule

// File: rtl/iirx_add.sv
`timescale 1ns/1ps
module iirx_add
  import iirx_pkg::*;
#(
  parameter int DW  = 16,
  parameter int STG = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  output logic signed [DW-1:0] s_o
);
  acc_t                 wide;
  logic signed [DW-1:0] sum_n;

  always_comb begin
    wide  = acc_t'(a_i) + acc_t'(b_i);
    sum_n = DW'(clamp_w(wide, DW));
  end

  iirx_delay #(.W(DW), .D(STG)) u_pipe (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (sum_n),
    .q_o  (s_o)
  );
endmodule

// File: rtl/iirx_interleave.sv
`timescale 1ns/1ps
module iirx_interleave #(
  parameter int N_CH    = 4,
  parameter int DW      = 16,
  parameter int CW      = 16,
  parameter int CF      = 14,
  parameter int MUL_STG = 2,
  parameter int ADD_STG = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] in_data,
  input  logic                 in_first,
  input  logic signed [CW-1:0] coef,
  output logic signed [DW-1:0] out_data,
  output logic                 out_first
);
  // Loop registers: MUL_STG + ADD_STG + BAL_STG must equal N_CH.
  localparam int BAL_RAW = N_CH - MUL_STG - ADD_STG;
  localparam int BAL_STG = (BAL_RAW < 0) ? 0 : BAL_RAW;

  generate
    if (MUL_STG < 1 || ADD_STG < 1 || BAL_RAW < 0 || CF < 1 || CF >= CW) begin : g_bad_cfg
      $error("iirx_interleave: need MUL_STG>=1, ADD_STG>=1, MUL_STG+ADD_STG<=N_CH, 1<=CF<CW");
    end
  endgenerate

  logic signed [DW-1:0] z_q;
  logic signed [DW-1:0] fb;
  logic signed [DW-1:0] prod;

  iirx_add #(.DW(DW), .STG(ADD_STG)) u_add (
    .clk  (clk),
    .rst_n(rst_n),
    .a_i  (in_data),
    .b_i  (prod),
    .s_o  (z_q)
  );

  iirx_delay #(.W(DW), .D(BAL_STG)) u_bal (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (z_q),
    .q_o  (fb)
  );

  iirx_mul #(.DW(DW), .CW(CW), .CF(CF), .STG(MUL_STG)) u_mul (
    .clk  (clk),
    .rst_n(rst_n),
    .z_i  (fb),
    .c_i  (coef),
    .p_o  (prod)
  );

  iirx_delay #(.W(1), .D(ADD_STG)) u_mark (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (in_first),
    .q_o  (out_first)
  );

  assign out_data = z_q;
endmodule

// File: rtl/iirx_interleave_chk.sv
`timescale 1ns/1ps
module iirx_interleave_chk #(
  parameter int DW      = 16,
  parameter int CW      = 16,
  parameter int MUL_STG = 2,
  parameter int ADD_STG = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic signed [DW-1:0] in_data,
  input logic                 in_first,
  input logic signed [CW-1:0] coef,
  input logic signed [DW-1:0] out_data,
  input logic                 out_first
);
  logic [15:0]   cyc;
  logic [15:0]   zrun;
  logic [DW-1:0] hist_d [ADD_STG];
  logic          hist_f [ADD_STG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc  <= '0;
      zrun <= '0;
      for (int k = 0; k < ADD_STG; k++) begin
        hist_d[k] <= '0;
        hist_f[k] <= 1'b0;
      end
    end else begin
      if (cyc != 16'hFFFF) cyc <= cyc + 16'd1;
      if (coef != '0) zrun <= '0;
      else if (zrun != 16'hFFFF) zrun <= zrun + 16'd1;
      hist_d[0] <= in_data;
      hist_f[0] <= in_first;
      for (int k = 1; k < ADD_STG; k++) begin
        hist_d[k] <= hist_d[k-1];
        hist_f[k] <= hist_f[k-1];
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cyc) < ADD_STG) |-> (out_data == '0 && !out_first)) else $error("reset quiet"); // R7

  AST_MARK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cyc) >= ADD_STG) |-> (out_first == hist_f[ADD_STG-1])) else $error("marker"); // R9

  AST_ZERO_COEF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(zrun) > MUL_STG + ADD_STG && int'(cyc) >= ADD_STG) |->
    (out_data == hist_d[ADD_STG-1])) else $error("pass-through"); // R8

  AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({out_data, out_first})) else $error("unknown output"); // R7
endmodule

bind iirx_interleave iirx_interleave_chk #(
  .DW(DW), .CW(CW), .MUL_STG(MUL_STG), .ADD_STG(ADD_STG)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_data  (in_data),
  .in_first (in_first),
  .coef     (coef),
  .out_data (out_data),
  .out_first(out_first)
);

// File: tb/iirx_interleave_test.sv
`timescale 1ns/1ps
module iirx_interleave_test;
  localparam int N   = 4;
  localparam int DW  = 16;
  localparam int CW  = 16;
  localparam int CF  = 14;
  localparam int MS  = 2;
  localparam int AS  = 1;
  localparam int LEN = 64;

  logic                 clk;
  logic                 rst_n;
  logic signed [DW-1:0] in_data;
  logic                 in_first;
  logic signed [CW-1:0] coef;
  logic signed [DW-1:0] out_data;
  logic                 out_first;

  int n_chk;
  int n_bad;
  bit done;
  int xs [LEN];
  int ex [LEN];
  int ef [LEN];

  iirx_interleave #(.N_CH(N), .DW(DW), .CW(CW), .CF(CF), .MUL_STG(MS), .ADD_STG(AS)) uut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_first(in_first),
    .coef(coef), .out_data(out_data), .out_first(out_first)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint clampl(input longint v);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (DW - 1)) - 1;
    lo = -(longint'(1) <<< (DW - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // Reference recursion from R1, R3, R4, R5.
  function automatic int step(input int x, input int c, input int z);
    longint p;
    longint r;
    p = longint'(c) * longint'(z);
    r = clampl((p + (longint'(1) <<< (CF - 1))) >>> CF);
    return int'(clampl(longint'(x) + r));
  endfunction

  function automatic int gen_x(input int kind, input int i);
    int ch;
    ch = i % N;
    case (kind)
      0: return ((i * 7919 + 13) % 65536) - 32768;
      1: begin
        if (i >= N) return 0;
        case (ch)
          0: return 1001;
          1: return -999;
          2: return 3;
          default: return 20000;
        endcase
      end
      2: return ((i * 37) % 201) - 100;
      default: begin
        case (ch)
          0: return 30000;
          1: return -30000;
          2: return ((i / N) % 2 == 1) ? 32767 : -32768;
          default: return 1;
        endcase
      end
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    in_data  = '0;
    in_first = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Streams LEN interleaved samples and checks each result ADD_STG cycles later.
  task automatic stream(input string req, input int kind, input int c);
    int zs [N];
    for (int k = 0; k < N; k++) zs[k] = 0;
    for (int i = 0; i < LEN; i++) begin
      xs[i] = gen_x(kind, i);
      zs[i % N] = step(xs[i], c, zs[i % N]);
      ex[i] = zs[i % N];
      ef[i] = (i % N == 0) ? 1 : 0;
    end
    coef = CW'(c);
    for (int i = 0; i < LEN + AS; i++) begin
      @(negedge clk);
      if (i >= AS) begin
        chk(req, int'(out_data), ex[i-AS]);
        chk({req, " R9"}, int'(out_first), ef[i-AS]);
      end
      if (i < LEN) begin
        in_data  = DW'(xs[i]);
        in_first = (i % N == 0);
      end else begin
        in_data  = '0;
        in_first = 1'b0;
      end
    end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; in_data = '0; in_first = 1'b0; coef = '0;
    repeat (2) @(negedge clk);
    chk("R7 data in reset", int'(out_data), 0);
    chk("R7 marker in reset", int'(out_first), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 data after release", int'(out_data), 0);
    chk("R7 marker after release", int'(out_first), 0);
  endtask

  task automatic t_passthrough();
    coef = '0;
    do_reset();
    stream("R8 R6 pass", 0, 0);
  endtask

  task automatic t_impulse();
    do_reset();
    stream("R1 R2 R3 impulse", 1, 8192);
  endtask

  task automatic t_negcoef();
    do_reset();
    stream("R1 R3 negative", 2, -12288);
  endtask

  task automatic t_saturate();
    do_reset();
    stream("R4 R5 saturate", 3, 32767);
  endtask

  task automatic t_reset_midstream();
    do_reset();
    stream("R1 pre-reset", 1, 8192);
    @(negedge clk);
    in_data = 16'sd500;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R7 async clear data", int'(out_data), 0);
    chk("R7 async clear marker", int'(out_first), 0);
    @(negedge clk);
    rst_n = 1'b1;
    in_data = '0;
    stream("R7 restart from zero", 1, 8192);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R6 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    t_reset_state();
    t_passthrough();
    t_impulse();
    t_negcoef();
    t_saturate();
    t_reset_midstream();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule